// File: doc/BRIEF.md
# Write-Back Set-Associative Cache Tag Engine

This block is the tag and state engine of a single-level, set-associative cache that uses a write-back policy. It takes a stream of read and write requests, each with a byte address. For every accepted request it reports one cycle later whether the access hit, whether a resident line had to be evicted, and whether that line was dirty and so must be written to the lower level. The block keeps no data. The lower level is treated as a fill and writeback path that always completes at once.

The block keeps a valid bit, a dirty bit and a tag for every line. It also keeps two rank orders per set: one refreshed on every access and one refreshed only on fills. The replacement policy is picked at run time on a 2-bit input and can be FIFO, LRU or MRU. Four running counters can be read at all times: hits, misses, evictions and writebacks. An invalidate command walks every line, one per cycle. It reports each dirty line it clears as a writeback and then raises a done flag.

Top module: `wb_cache_ctrl`

## Requirements
- R1: The address is split, from the least significant bit upward, into an offset of log2(LINE_BYTES) bits, an index of log2(SETS) bits and a tag made of the remaining bits, where SETS = CACHE_BYTES/(LINE_BYTES*WAYS). Two addresses that differ only in the offset reach the same line, so the second access hits.
- R2: A write hit sets the line's dirty bit and reports no eviction and no writeback. A dirty line causes a writeback only when it is evicted or invalidated.
- R3: On a miss, an invalid way of the set is filled before any valid way is evicted. Evicting a clean line reports an eviction without a writeback, and a hit never reports an eviction.
- R4: With policy 0 (FIFO), the victim is the valid way that was filled earliest in the set. Hits do not change that order.
- R5: With policy 1 (LRU, and also for the value 3), every hit and every fill makes the way most recent, and the victim is the least recently accessed way.
- R6: With policy 2 (MRU), the victim is the way of the set that was accessed most recently, whether by a hit or by a fill.
- R7: A write miss allocates the line and leaves it dirty, so the later eviction of that line reports a writeback.
- R8: An `inval_start` pulse sets `inval_busy` and walks all SETS*WAYS lines, one per cycle. It clears every line and pulses `flush_wb` once for each dirty line. `inval_done` pulses for one cycle exactly SETS*WAYS+1 cycles after the start is sampled, and `inval_busy` falls at the same time. Requests that arrive while the walk runs are ignored.
- R9: `hit_count`, `miss_count`, `evict_count` and `wb_count` add one for each hit, miss, eviction and writeback. Writebacks caused by invalidation are counted as well. The counters change at the same edge as the response.
- R10: A request is accepted when `req_valid` is high while `inval_busy` and `inval_start` are low. Its response appears with `resp_valid` high for one cycle after the next clock edge, and `resp_valid` is low otherwise.
- R11: After reset all lines are invalid, all counters are zero, and `resp_valid`, `inval_busy`, `flush_wb` and `inval_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Replacement policy: 0 FIFO, 1 LRU, 2 MRU, 3 LRU |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address |
| inval_start | input | 1 | Start invalidation of all lines |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Access hit |
| resp_evict | output | 1 | A valid line was evicted |
| resp_wb | output | 1 | The evicted line was dirty |
| inval_busy | output | 1 | Invalidation walk running |
| flush_wb | output | 1 | Dirty line cleared by invalidation this cycle |
| inval_done | output | 1 | Invalidation finished (one-cycle pulse) |
| hit_count | output | CNT_W | Hit counter |
| miss_count | output | CNT_W | Miss counter |
| evict_count | output | CNT_W | Eviction counter |
| wb_count | output | CNT_W | Writeback counter |

## Verification
Each request result and the counter updates that go with it become visible after the first clock edge that follows the request. The driver sets inputs on the falling edge, and the monitor samples at the next falling edge, where it takes the next expected triple from the scoreboard queue. The invalidation walk is due SETS*WAYS+1 edges after the start is sampled, so the bench counts falling edges from the start until `inval_done` and tallies the `flush_wb` pulses it sees on the way. The victim choice under each policy is checked through hand-worked access sequences whose follow-up hits and misses show which way was removed.

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl #(
  parameter int CACHE_BYTES = 256,
  parameter int LINE_BYTES  = 16,
  parameter int WAYS        = 4,
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        policy,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              inval_start,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_evict,
  output logic              resp_wb,
  output logic              inval_busy,
  output logic              flush_wb,
  output logic              inval_done,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  evict_count,
  output logic [CNT_W-1:0]  wb_count
);
  localparam int SETS  = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int RW    = $clog2(WAYS);
  localparam int LINES = SETS * WAYS;
  localparam int PW    = $clog2(LINES + 1);
  localparam logic [1:0] POL_FIFO = 2'd0;
  localparam logic [1:0] POL_MRU  = 2'd2;

  logic [WAYS-1:0]  valid [SETS];
  logic [WAYS-1:0]  dirty [SETS];
  logic [TAG_W-1:0] tags  [SETS][WAYS];
  logic [RW-1:0]    urank [SETS][WAYS];
  logic [RW-1:0]    frank [SETS][WAYS];
  logic [PW-1:0]    ptr;

  wire [IDX_W-1:0] idx    = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] tg     = req_addr[ADDR_W-1 -: TAG_W];
  wire             accept = req_valid && !inval_busy && !inval_start;
  logic unused_offset;
  assign unused_offset = ^req_addr[OFF_W-1:0];

  logic          hit, have_inv, evict, wb_need;
  logic [RW-1:0] hway, iway, vway, tway;

  always_comb begin
    hit = 1'b0; hway = '0; have_inv = 1'b0; iway = '0; vway = '0;
    for (int w = 0; w < WAYS; w++)
      if (valid[idx][w] && tags[idx][w] == tg) begin hit = 1'b1; hway = RW'(w); end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid[idx][w]) begin have_inv = 1'b1; iway = RW'(w); end
    for (int w = 0; w < WAYS; w++) begin
      if (policy == POL_FIFO) begin
        if (frank[idx][w] == RW'(WAYS - 1)) vway = RW'(w);
      end else if (policy == POL_MRU) begin
        if (urank[idx][w] == '0) vway = RW'(w);
      end else begin
        if (urank[idx][w] == RW'(WAYS - 1)) vway = RW'(w);
      end
    end
    tway    = hit ? hway : (have_inv ? iway : vway);
    evict   = !hit && !have_inv;
    wb_need = evict && dirty[idx][vway];
  end

  wire [IDX_W-1:0] fset = IDX_W'(32'(ptr) / WAYS);
  wire [RW-1:0]    fway = RW'(32'(ptr) % WAYS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid[s] <= '0;
        dirty[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tags[s][w]  <= '0;
          urank[s][w] <= RW'(w);
          frank[s][w] <= RW'(w);
        end
      end
      ptr <= '0; inval_busy <= 1'b0; flush_wb <= 1'b0; inval_done <= 1'b0;
      resp_valid <= 1'b0; resp_hit <= 1'b0; resp_evict <= 1'b0; resp_wb <= 1'b0;
      hit_count <= '0; miss_count <= '0; evict_count <= '0; wb_count <= '0;
    end else begin
      resp_valid <= 1'b0;
      flush_wb   <= 1'b0;
      inval_done <= 1'b0;
      if (inval_busy) begin
        if (ptr == PW'(LINES)) begin
          inval_busy <= 1'b0;
          inval_done <= 1'b1;
        end else begin
          if (valid[fset][fway] && dirty[fset][fway]) begin
            flush_wb <= 1'b1;
            wb_count <= wb_count + 1'b1;
          end
          valid[fset][fway] <= 1'b0;
          dirty[fset][fway] <= 1'b0;
          ptr <= ptr + 1'b1;
        end
      end else if (inval_start) begin
        inval_busy <= 1'b1;
        ptr        <= '0;
      end else if (accept) begin
        resp_valid <= 1'b1;
        resp_hit   <= hit;
        resp_evict <= evict;
        resp_wb    <= wb_need;
        if (hit) hit_count <= hit_count + 1'b1;
        else     miss_count <= miss_count + 1'b1;
        if (evict)   evict_count <= evict_count + 1'b1;
        if (wb_need) wb_count <= wb_count + 1'b1;
        valid[idx][tway] <= 1'b1;
        tags[idx][tway]  <= tg;
        dirty[idx][tway] <= hit ? (dirty[idx][tway] | req_write) : req_write;
        for (int w = 0; w < WAYS; w++) begin
          if (RW'(w) == tway) urank[idx][w] <= '0;
          else if (urank[idx][w] < urank[idx][tway]) urank[idx][w] <= urank[idx][w] + 1'b1;
          if (!hit) begin
            if (RW'(w) == tway) frank[idx][w] <= '0;
            else if (frank[idx][w] < frank[idx][tway]) frank[idx][w] <= frank[idx][w] + 1'b1;
          end
        end
      end
    end
  end

  assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> resp_valid);
  assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !resp_valid);
  assert_wb_needs_evict_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_wb) |-> resp_evict);
  assert_hit_never_evicts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> !resp_evict);
  assert_flush_inside_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_wb |-> inval_busy);
  assert_done_ends_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inval_done |-> (!inval_busy && $fell(inval_busy)));
  assert_hit_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> hit_count == $past(hit_count) + 1'b1);
  assert_miss_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> miss_count == $past(miss_count) + 1'b1);
endmodule

// File: tb/test_wb_cache_ctrl.sv
module test_wb_cache_ctrl;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int LINES  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] policy = 2'd0;
  logic req_valid = 1'b0, req_write = 1'b0, inval_start = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic resp_valid, resp_hit, resp_evict, resp_wb, inval_busy, flush_wb, inval_done;
  logic [CNT_W-1:0] hit_count, miss_count, evict_count, wb_count;

  wb_cache_ctrl i_wb_cache_ctrl (
    .clk(clk), .rst_n(rst_n), .policy(policy), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .inval_start(inval_start),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_evict(resp_evict),
    .resp_wb(resp_wb), .inval_busy(inval_busy), .flush_wb(flush_wb),
    .inval_done(inval_done), .hit_count(hit_count), .miss_count(miss_count),
    .evict_count(evict_count), .wb_count(wb_count));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, flush_seen = 0, cycles = 0;
  int exp_hit = 0, exp_miss = 0, exp_ev = 0, exp_wb = 0;
  bit finished = 0;
  logic [2:0] q_exp[$];
  string      q_tag[$];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] adr(input int t, input int s, input int off);
    return ADDR_W'(t * 64 + s * 16 + off);
  endfunction

  task automatic access(input bit wr, input logic [ADDR_W-1:0] a,
                        input bit h, input bit ev, input bit wb, input string req);
    q_exp.push_back({h, ev, wb});
    q_tag.push_back(req);
    if (h) exp_hit++; else exp_miss++;
    if (ev) exp_ev++;
    if (wb) exp_wb++;
    req_valid = 1'b1; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (flush_wb) flush_seen++;
      if (resp_valid) begin
        if (q_exp.size() == 0) check("R10 unexpected response", 1, 0);
        else begin
          logic [2:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          check(t, int'({resp_hit, resp_evict, resp_wb}), int'(e));
        end
      end
    end
  end

  task automatic invalidate(input int exp_flush);
    int n;
    int start_seen;
    start_seen = flush_seen;
    inval_start = 1'b1;
    @(negedge clk);
    inval_start = 1'b0;
    check("R8 busy after start", int'(inval_busy), 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = adr(9, 3, 0);
    n = 0;
    while (n < 100) begin
      @(negedge clk);
      n++;
      if (inval_done) break;
    end
    req_valid = 1'b0;
    check("R8 done latency", n, LINES + 1);
    check("R8 busy low at done", int'(inval_busy), 0);
    check("R8 flush writebacks", flush_seen - start_seen, exp_flush);
    exp_wb += exp_flush;
    @(negedge clk);
    check("R8 done is one pulse", int'(inval_done), 0);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !finished) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 resp_valid after reset", int'(resp_valid), 0);
    check("R11 busy after reset", int'(inval_busy), 0);
    check("R11 counters after reset",
          int'(hit_count) + int'(miss_count) + int'(evict_count) + int'(wb_count), 0);

    policy = 2'd0;
    access(0, adr(1, 0, 0), 0, 0, 0, "R3 first fill");
    access(0, adr(1, 0, 5), 1, 0, 0, "R1 offset hit");
    access(1, adr(2, 0, 0), 0, 0, 0, "R7 write miss allocate");
    access(0, adr(3, 0, 0), 0, 0, 0, "R3 fill invalid way");
    access(0, adr(4, 0, 0), 0, 0, 0, "R3 fill last way");
    access(0, adr(1, 0, 15), 1, 0, 0, "R4 hit before eviction");
    access(0, adr(5, 0, 0), 0, 1, 0, "R4 evict oldest fill clean");
    access(0, adr(6, 0, 0), 0, 1, 1, "R7 dirty write-miss line written back");
    access(0, adr(1, 0, 0), 0, 1, 0, "R4 earlier hit not refreshed");
    access(1, adr(5, 0, 0), 1, 0, 0, "R2 write hit no writeback");
    access(0, adr(4, 0, 0), 1, 0, 0, "R4 fourth fill still resident");
    repeat (2) @(negedge clk);
    invalidate(1);
    access(0, adr(5, 0, 0), 0, 0, 0, "R8 line cleared by invalidate");
    access(0, adr(9, 3, 0), 0, 0, 0, "R8 request during walk ignored");

    policy = 2'd1;
    for (int t = 1; t <= 4; t++) access(0, adr(t, 1, 0), 0, 0, 0, "R5 fill");
    access(0, adr(1, 1, 0), 1, 0, 0, "R5 hit");
    access(0, adr(5, 1, 0), 0, 1, 0, "R5 evict least recent");
    access(0, adr(1, 1, 0), 1, 0, 0, "R5 refreshed way kept");
    access(0, adr(2, 1, 0), 0, 1, 0, "R5 victim was removed");
    access(0, adr(4, 1, 0), 1, 0, 0, "R5 hit");
    access(0, adr(3, 1, 0), 0, 1, 0, "R5 victim was removed");
    access(0, adr(1, 1, 0), 1, 0, 0, "R5 recent way kept");
    access(0, adr(5, 1, 0), 0, 1, 0, "R5 victim was removed");

    policy = 2'd2;
    for (int t = 1; t <= 4; t++) access(0, adr(t, 2, 0), 0, 0, 0, "R6 fill");
    access(0, adr(2, 2, 0), 1, 0, 0, "R6 hit");
    access(0, adr(5, 2, 0), 0, 1, 0, "R6 evict most recent hit");
    access(0, adr(2, 2, 0), 0, 1, 0, "R6 hit way gone, evict fresh fill");
    access(0, adr(1, 2, 0), 1, 0, 0, "R6 old way kept");
    access(0, adr(5, 2, 0), 0, 1, 0, "R6 fill way was evicted");
    access(0, adr(3, 2, 0), 1, 0, 0, "R6 hit");
    access(1, adr(3, 2, 0), 1, 0, 0, "R2 write hit no writeback");
    access(0, adr(6, 2, 0), 0, 1, 1, "R2 dirty victim written back");
    access(0, adr(4, 2, 0), 1, 0, 0, "R6 untouched way kept");
    repeat (2) @(negedge clk);
    invalidate(0);

    check("R10 all responses seen", q_exp.size(), 0);
    check("R9 hit count", int'(hit_count), exp_hit);
    check("R9 miss count", int'(miss_count), exp_miss);
    check("R9 eviction count", int'(evict_count), exp_ev);
    check("R9 writeback count", int'(wb_count), exp_wb);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule